// File: doc/BRIEF.md
# SD/MMC Host Command and Status Register Front End

This block is the register side of an SD/MMC host controller. Software writes a command index, a 32-bit argument, a response type, a command type and the block geometry into byte-wide registers, then sets a start bit. The block sends a one-cycle start pulse to the command engine, tracks the command until its response and any data phase finish, and collects completion and error events from the line engines into write-one-to-clear status bytes. Each status bit has its own mask, and one interrupt output summarises them.

A sequencer with four states tracks the command. IDLE waits for the start bit and goes to ISSUE, latching the command type. ISSUE drives the start pulse for one cycle and goes to WAIT_RSP. WAIT_RSP goes back to IDLE on a response timeout, a data timeout, or a response-done event when the type has no data phase. A response-done event for a data type goes to DATA instead. DATA returns to IDLE on a data timeout, on a read or write CRC error when abort-on-CRC is set, on the first block-done event for a single-block type, or on the block that completes the programmed count for a multi-block type. A soft reset sends every state straight to IDLE.

Top module: `sd_cmd_front`

Byte addresses: 0x0 control, 0x1 command index, 0x2 response type, 0x3 bus configuration, 0x4 to 0x7 argument (least significant byte first), 0x8/0x9 block length low/high, 0xA/0xB block count low/high, 0xC mask 0, 0xD mask 1, 0xE status 0, 0xF status 1. Other addresses read 0.

## Requirements
- R1: Register fields appear on the outputs and read back.
  - Command index is bits 5:0 at 0x1.
  - Response type is bits 3:0 at 0x2.
  - Bus configuration bits 6:0 are at 0x3.
  - The argument is built from 0x4 to 0x7, least significant byte first.
  - Block count is 16 bits at 0xA/0xB.
  - In the 16-bit block length at 0x8/0x9, bits 10:0 hold the block size minus one, bit 11 is abort-on-CRC, bit 13 selects the GPI card-detect source and bit 15 enables the interrupt.
  - In the control byte, bits 7:4 are the command type and bit 2 is the write flag.
- R2: Writing control bit 0 while the sequencer is idle produces a `cmd_start` pulse exactly one cycle long. The pulse is high during the second cycle after the write edge.
- R3: Control bit 0 reads 1 from the write until the end of the start pulse, and reads 0 from the next cycle on.
- R4: Writing control bit 3 drives `rsp_fifo_clr` high for the one cycle after the write edge. Bit 3 always reads 0.
- R5: A start write while a command is outstanding is ignored: no pulse follows and bit 0 stays 0.
- R6: Command types 1 and 2 are single-block and 3 and 4 are multi-block; these four types have a data phase. Types 0, 7 and all others have no data phase.
  - A single-block data phase ends on the first block-done event.
  - A multi-block data phase ends when the number of block-done events equals the block count, where a count of 0 means 65536.
  - Any data phase also ends on a data timeout (status 1 bit 4).
  - A read CRC error (bit 6) or write CRC error (bit 7) ends a data phase only when abort-on-CRC is set.
- R7: The status 0 bits are:
  - bit 7 is set by device insertion;
  - bit 6 is set by card detect, taken from the GPI input when block length bit 13 is 1 and from the DAT3 input otherwise;
  - bit 5 is set by any block-done event;
  - bit 4 is set when the multi-block count is reached;
  - bit 1 shows the write-protect input live;
  - bits 3:2 and 0 read 0.
- R8: Status 1 bit n is set when `line_evt[n]` is high. The event bits are:
  - 0: SDIO interrupt
  - 1: command-response done
  - 2: response timeout
  - 3: auto-stop done
  - 4: data timeout
  - 5: response CRC error
  - 6: read CRC error
  - 7: write CRC error
- R9: Writing 1 to a status bit clears it. An event that arrives in the same cycle as the clear wins. The live write-protect bit is not cleared.
- R10: `irq` is high only when block length bit 15 is set and some status bit is set whose mask bit is also set. Mask 1 covers all 8 bits. Mask 0 covers bits 7:4, and its bits 3:0 read 0.
- R11: Writing bus configuration bit 7 is a soft reset. It clears both status bytes and the start bit and returns the sequencer to IDLE. The masks and command fields are kept. Bus configuration stores the written bits 6:0 and bit 7 reads 0.
- R12: After reset, all registers read 0 and `irq` and `cmd_start` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| line_evt | input | 8 | Event pulses from the line engines, one per status 1 bit |
| blk_done_evt | input | 1 | One data block finished |
| cd_gpi_evt | input | 1 | Card-detect change from the GPI pin |
| cd_dat3_evt | input | 1 | Card-detect change seen on DAT3 |
| dev_ins_evt | input | 1 | Device insertion event |
| wp_level | input | 1 | Write-protect switch level |
| cmd_start | output | 1 | One-cycle command start pulse |
| rsp_fifo_clr | output | 1 | One-cycle response FIFO clear |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| rsp_type | output | 4 | Response type |
| cmd_type | output | 4 | Command type |
| xfer_write | output | 1 | Write direction flag |
| blk_len_m1 | output | 11 | Block size minus one |
| blk_count | output | 16 | Block count |
| bus_cfg | output | 8 | Bus configuration (bit 7 always 0) |
| irq | output | 1 | Interrupt request |

## Verification
The sequencer state is not visible directly. The ports show it one write later:
- A sequencer stuck outside IDLE swallows the next start, so no `cmd_start` pulse appears within three cycles.
- A sequencer that leaves DATA early accepts a start that should have been refused.

A wrong block counter shows on status 0 bit 4 on the very next read: the bit is set one block too early or still clear after the last block. A status byte that keeps or drops bits wrongly shows on read-back and on `irq` in the same cycle as the read.

// File: rtl/sd_fe_pkg.sv
package sd_fe_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ISSUE,
        S_WAIT_RSP,
        S_DATA
    } seq_state_t;

    localparam logic [3:0] A_CTRL   = 4'h0;
    localparam logic [3:0] A_INDEX  = 4'h1;
    localparam logic [3:0] A_RSPT   = 4'h2;
    localparam logic [3:0] A_BUS    = 4'h3;
    localparam logic [3:0] A_ARG0   = 4'h4;
    localparam logic [3:0] A_BLEN_L = 4'h8;
    localparam logic [3:0] A_BLEN_H = 4'h9;
    localparam logic [3:0] A_BCNT_L = 4'hA;
    localparam logic [3:0] A_BCNT_H = 4'hB;
    localparam logic [3:0] A_MASK0  = 4'hC;
    localparam logic [3:0] A_MASK1  = 4'hD;
    localparam logic [3:0] A_STAT0  = 4'hE;
    localparam logic [3:0] A_STAT1  = 4'hF;

    localparam int EV_RSP_DONE = 1;
    localparam int EV_RSP_TO   = 2;
    localparam int EV_DATA_TO  = 4;
    localparam int EV_RCRC     = 6;
    localparam int EV_WCRC     = 7;

    function automatic logic type_has_data(input logic [3:0] t);
        return (t >= 4'd1) && (t <= 4'd4);
    endfunction

    function automatic logic type_is_multi(input logic [3:0] t);
        return (t == 4'd3) || (t == 4'd4);
    endfunction

endpackage

// File: rtl/sd_fe_regs.sv
module sd_fe_regs
    import sd_fe_pkg::*;
#(
    parameter int ARG_BYTES = 4,
    parameter int LEN_W     = 11,
    parameter int CNT_W     = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr,
    input  logic [3:0]             addr,
    input  logic [7:0]             wdata,
    input  logic                   seq_idle,
    input  logic                   start_clr,
    output logic                   soft_rst,
    output logic                   start_bit,
    output logic                   fifo_clr,
    output logic [5:0]             cmd_index,
    output logic [8*ARG_BYTES-1:0] cmd_arg,
    output logic [3:0]             rsp_type,
    output logic [3:0]             cmd_type,
    output logic                   xfer_write,
    output logic [LEN_W-1:0]       blk_len_m1,
    output logic                   crc_abort,
    output logic                   cd_gpi_sel,
    output logic                   irq_en,
    output logic [CNT_W-1:0]       blk_count,
    output logic [7:0]             bus_cfg,
    output logic [7:0]             rdata
);

    localparam int LEN_HI_W = LEN_W - 8;

    logic [6:0]             bus_q;
    logic [8*ARG_BYTES-1:0] arg_q;

    assign soft_rst = wr && (addr == A_BUS) && wdata[7];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_bit  <= 1'b0;
            fifo_clr   <= 1'b0;
            cmd_type   <= '0;
            xfer_write <= 1'b0;
        end else begin
            fifo_clr <= wr && (addr == A_CTRL) && wdata[3];
            if (wr && addr == A_CTRL) begin
                cmd_type   <= wdata[7:4];
                xfer_write <= wdata[2];
            end
            if (soft_rst || start_clr)
                start_bit <= 1'b0;
            else if (wr && addr == A_CTRL && seq_idle)
                start_bit <= wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_index  <= '0;
            rsp_type   <= '0;
            bus_q      <= '0;
            blk_len_m1 <= '0;
            crc_abort  <= 1'b0;
            cd_gpi_sel <= 1'b0;
            irq_en     <= 1'b0;
            blk_count  <= '0;
        end else if (wr) begin
            unique case (addr)
                A_INDEX:  cmd_index <= wdata[5:0];
                A_RSPT:   rsp_type  <= wdata[3:0];
                A_BUS:    bus_q     <= wdata[6:0];
                A_BLEN_L: blk_len_m1[7:0] <= wdata;
                A_BLEN_H: begin
                    blk_len_m1[LEN_W-1:8] <= wdata[LEN_HI_W-1:0];
                    crc_abort  <= wdata[3];
                    cd_gpi_sel <= wdata[5];
                    irq_en     <= wdata[7];
                end
                A_BCNT_L: blk_count[7:0]       <= wdata;
                A_BCNT_H: blk_count[CNT_W-1:8] <= wdata[CNT_W-9:0];
                default: ;
            endcase
        end
    end

    for (genvar i = 0; i < ARG_BYTES; i++) begin : g_arg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                arg_q[8*i +: 8] <= '0;
            else if (wr && addr == 4'(A_ARG0 + i))
                arg_q[8*i +: 8] <= wdata;
        end
    end

    assign cmd_arg = arg_q;
    assign bus_cfg = {1'b0, bus_q};

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_CTRL:   rdata = {cmd_type, 1'b0, xfer_write, 1'b0, start_bit};
            A_INDEX:  rdata = {2'b0, cmd_index};
            A_RSPT:   rdata = {4'b0, rsp_type};
            A_BUS:    rdata = {1'b0, bus_q};
            A_BLEN_L: rdata = blk_len_m1[7:0];
            A_BLEN_H: rdata = {irq_en, 1'b0, cd_gpi_sel, 1'b0, crc_abort,
                               blk_len_m1[LEN_W-1:8]};
            A_BCNT_L: rdata = blk_count[7:0];
            A_BCNT_H: rdata = blk_count[CNT_W-1:8];
            default: begin
                for (int i = 0; i < ARG_BYTES; i++)
                    if (addr == 4'(A_ARG0 + i))
                        rdata = arg_q[8*i +: 8];
            end
        endcase
    end

    // R3: the start bit is gone the cycle after the sequencer asks to clear it
    a_r3_start_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        start_clr |=> !start_bit);

    // R5: while a command is outstanding the start bit cannot rise
    a_r5_busy_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_idle && !start_bit) |=> !start_bit);

endmodule

// File: rtl/sd_fe_seq.sv
module sd_fe_seq
    import sd_fe_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             start_bit,
    input  logic [3:0]       cmd_type,
    input  logic             crc_abort,
    input  logic             ev_rsp_done,
    input  logic             ev_rsp_to,
    input  logic             ev_data_to,
    input  logic             ev_crc,
    input  logic             blk_done_evt,
    input  logic [CNT_W-1:0] blk_count,
    output logic             cmd_start,
    output logic             start_clr,
    output logic             seq_idle,
    output logic             mblk_evt
);

    seq_state_t       state, state_nx;
    logic [3:0]       typ_q;
    logic [CNT_W-1:0] done_cnt;
    logic [CNT_W-1:0] cnt_inc;
    logic             multi_q;
    logic             last_blk;

    assign multi_q  = type_is_multi(typ_q);
    assign cnt_inc  = done_cnt + CNT_W'(1);
    assign last_blk = blk_done_evt && (cnt_inc == blk_count);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            typ_q    <= '0;
            done_cnt <= '0;
        end else begin
            state <= state_nx;
            if (state == S_IDLE && start_bit)
                typ_q <= cmd_type;
            if (state == S_ISSUE)
                done_cnt <= '0;
            else if (state == S_DATA && multi_q && blk_done_evt)
                done_cnt <= cnt_inc;
        end
    end

    always_comb begin
        state_nx = state;
        if (soft_rst) begin
            state_nx = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:
                    if (start_bit) state_nx = S_ISSUE;
                S_ISSUE:
                    state_nx = S_WAIT_RSP;
                S_WAIT_RSP:
                    if (ev_rsp_to || ev_data_to)
                        state_nx = S_IDLE;
                    else if (ev_rsp_done)
                        state_nx = type_has_data(typ_q) ? S_DATA : S_IDLE;
                S_DATA:
                    if (ev_data_to || (crc_abort && ev_crc))
                        state_nx = S_IDLE;
                    else if (multi_q ? last_blk : blk_done_evt)
                        state_nx = S_IDLE;
                default:
                    state_nx = S_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd_start = (state == S_ISSUE);
        start_clr = (state == S_ISSUE);
        seq_idle  = (state == S_IDLE);
        mblk_evt  = (state == S_DATA) && multi_q && last_blk;
    end

    // R2: the start pulse is exactly one cycle wide
    a_r2_one_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> !cmd_start);

    // R11: a soft reset always lands in IDLE
    a_r11_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> seq_idle);

endmodule

// File: rtl/sd_fe_stat.sv
module sd_fe_stat
    import sd_fe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [3:0] addr,
    input  logic [7:0] wdata,
    input  logic       soft_rst,
    input  logic [7:0] line_evt,
    input  logic       blk_done_evt,
    input  logic       mblk_evt,
    input  logic       cd_gpi_evt,
    input  logic       cd_dat3_evt,
    input  logic       cd_gpi_sel,
    input  logic       dev_ins_evt,
    input  logic       wp_level,
    input  logic       irq_en,
    output logic       irq,
    output logic [7:0] rdata
);

    logic [7:4] stat0_q, mask0_q, set0, clr0;
    logic [7:0] stat1_q, mask1_q, clr1;
    logic       cd_evt;

    assign cd_evt = cd_gpi_sel ? cd_gpi_evt : cd_dat3_evt;
    assign set0   = {dev_ins_evt, cd_evt, blk_done_evt, mblk_evt};
    assign clr0   = (wr && addr == A_STAT0) ? wdata[7:4] : 4'h0;
    assign clr1   = (wr && addr == A_STAT1) ? wdata : 8'h00;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat0_q <= '0;
            stat1_q <= '0;
            mask0_q <= '0;
            mask1_q <= '0;
        end else begin
            if (soft_rst) begin
                stat0_q <= '0;
                stat1_q <= '0;
            end else begin
                stat0_q <= (stat0_q & ~clr0) | set0;
                stat1_q <= (stat1_q & ~clr1) | line_evt;
            end
            if (wr && addr == A_MASK0) mask0_q <= wdata[7:4];
            if (wr && addr == A_MASK1) mask1_q <= wdata;
        end
    end

    assign irq = irq_en && (|(stat0_q & mask0_q) || |(stat1_q & mask1_q));

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_MASK0: rdata = {mask0_q, 4'h0};
            A_MASK1: rdata = mask1_q;
            A_STAT0: rdata = {stat0_q, 2'b00, wp_level, 1'b0};
            A_STAT1: rdata = stat1_q;
            default: rdata = '0;
        endcase
    end

    // R7: a multi-block completion only coincides with a block-done event
    a_r7_mblk_on_block: assert property (@(posedge clk) disable iff (!rst_n)
        mblk_evt |-> blk_done_evt);

    // R9: a full clear of status 1 with no event empties the byte
    a_r9_stat1_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_STAT1 && wdata == 8'hFF && line_evt == 8'h00)
        |=> (stat1_q == 8'h00));

endmodule

// File: rtl/sd_cmd_front.sv
module sd_cmd_front
    import sd_fe_pkg::*;
#(
    parameter int ARG_BYTES = 4,
    parameter int LEN_W     = 11,
    parameter int CNT_W     = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr,
    input  logic [3:0]             reg_addr,
    input  logic [7:0]             reg_wdata,
    output logic [7:0]             reg_rdata,
    input  logic [7:0]             line_evt,
    input  logic                   blk_done_evt,
    input  logic                   cd_gpi_evt,
    input  logic                   cd_dat3_evt,
    input  logic                   dev_ins_evt,
    input  logic                   wp_level,
    output logic                   cmd_start,
    output logic                   rsp_fifo_clr,
    output logic [5:0]             cmd_index,
    output logic [8*ARG_BYTES-1:0] cmd_arg,
    output logic [3:0]             rsp_type,
    output logic [3:0]             cmd_type,
    output logic                   xfer_write,
    output logic [LEN_W-1:0]       blk_len_m1,
    output logic [CNT_W-1:0]       blk_count,
    output logic [7:0]             bus_cfg,
    output logic                   irq
);

    logic       soft_rst, start_bit, seq_idle, start_clr, mblk_evt;
    logic       crc_abort, cd_gpi_sel, irq_en;
    logic [7:0] regs_rdata, stat_rdata;

    sd_fe_regs #(.ARG_BYTES(ARG_BYTES), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .seq_idle(seq_idle), .start_clr(start_clr),
        .soft_rst(soft_rst), .start_bit(start_bit), .fifo_clr(rsp_fifo_clr),
        .cmd_index(cmd_index), .cmd_arg(cmd_arg), .rsp_type(rsp_type),
        .cmd_type(cmd_type), .xfer_write(xfer_write),
        .blk_len_m1(blk_len_m1), .crc_abort(crc_abort),
        .cd_gpi_sel(cd_gpi_sel), .irq_en(irq_en), .blk_count(blk_count),
        .bus_cfg(bus_cfg), .rdata(regs_rdata)
    );

    sd_fe_seq #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .start_bit(start_bit), .cmd_type(cmd_type), .crc_abort(crc_abort),
        .ev_rsp_done(line_evt[EV_RSP_DONE]), .ev_rsp_to(line_evt[EV_RSP_TO]),
        .ev_data_to(line_evt[EV_DATA_TO]),
        .ev_crc(line_evt[EV_RCRC] | line_evt[EV_WCRC]),
        .blk_done_evt(blk_done_evt), .blk_count(blk_count),
        .cmd_start(cmd_start), .start_clr(start_clr), .seq_idle(seq_idle),
        .mblk_evt(mblk_evt)
    );

    sd_fe_stat u_stat (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .soft_rst(soft_rst), .line_evt(line_evt),
        .blk_done_evt(blk_done_evt), .mblk_evt(mblk_evt),
        .cd_gpi_evt(cd_gpi_evt), .cd_dat3_evt(cd_dat3_evt),
        .cd_gpi_sel(cd_gpi_sel), .dev_ins_evt(dev_ins_evt),
        .wp_level(wp_level), .irq_en(irq_en), .irq(irq), .rdata(stat_rdata)
    );

    assign reg_rdata = regs_rdata | stat_rdata;

    // R10: the interrupt never fires while the enable flag is clear
    a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

endmodule

// File: tb/sd_cmd_front_bench.sv
module sd_cmd_front_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [7:0]  line_evt = '0;
    logic        blk_done_evt = 1'b0, cd_gpi_evt = 1'b0, cd_dat3_evt = 1'b0;
    logic        dev_ins_evt = 1'b0, wp_level = 1'b0;
    logic        cmd_start, rsp_fifo_clr, xfer_write, irq;
    logic [5:0]  cmd_index;
    logic [31:0] cmd_arg;
    logic [3:0]  rsp_type, cmd_type;
    logic [10:0] blk_len_m1;
    logic [15:0] blk_count;
    logic [7:0]  bus_cfg;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sd_cmd_front u_sd_cmd_front (.*);

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse_line(input logic [7:0] v);
        line_evt = v;
        step();
        line_evt = '0;
    endtask

    task automatic pulse_blk();
        blk_done_evt = 1'b1;
        step();
        blk_done_evt = 1'b0;
    endtask

    task automatic count_starts(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            step();
            if (cmd_start) c++;
        end
    endtask

    task automatic clear_stats();
        wr(4'hE, 8'hFF);
        wr(4'hF, 8'hFF);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), d);
            chk("R12 reg reset", d, 0);
        end
        chk("R12 irq reset", irq, 0);
        chk("R12 start reset", cmd_start, 0);
    endtask

    task automatic t_fields();
        logic [7:0] d;
        wr(4'h1, 8'h2A);
        wr(4'h4, 8'h78); wr(4'h5, 8'h56); wr(4'h6, 8'h34); wr(4'h7, 8'h12);
        wr(4'h2, 8'h09);
        wr(4'h8, 8'hFF); wr(4'h9, 8'h01);
        wr(4'hA, 8'h03); wr(4'hB, 8'h00);
        wr(4'h3, 8'h12);
        wr(4'h0, 8'h54);
        chk("R1 index", cmd_index, 6'h2A);
        chk("R1 arg", cmd_arg, 32'h12345678);
        chk("R1 rsp type", rsp_type, 4'h9);
        chk("R1 blk len", blk_len_m1, 11'h1FF);
        chk("R1 blk count", blk_count, 16'h0003);
        chk("R1 bus cfg", bus_cfg, 8'h12);
        chk("R1 cmd type", cmd_type, 4'h5);
        chk("R1 write flag", xfer_write, 1'b1);
        rd(4'h6, d);
        chk("R1 arg byte readback", d, 8'h34);
        rd(4'h0, d);
        chk("R1 ctrl readback", d, 8'h54);
        wr(4'h0, 8'h00);
    endtask

    task automatic t_start();
        logic [7:0] d;
        wr(4'h0, 8'h01);
        chk("R2 no pulse in first cycle", cmd_start, 0);
        rd(4'h0, d);
        chk("R3 start bit set", d[0], 1);
        step();
        chk("R2 pulse", cmd_start, 1);
        rd(4'h0, d);
        chk("R3 start bit during pulse", d[0], 1);
        step();
        chk("R2 pulse over", cmd_start, 0);
        rd(4'h0, d);
        chk("R3 start bit cleared", d[0], 0);
        pulse_line(8'h02);
        clear_stats();
    endtask

    task automatic t_fifo();
        logic [7:0] d;
        wr(4'h0, 8'h08);
        chk("R4 fifo clear pulse", rsp_fifo_clr, 1);
        rd(4'h0, d);
        chk("R4 bit3 reads 0", d, 8'h00);
        step();
        chk("R4 fifo clear ends", rsp_fifo_clr, 0);
    endtask

    task automatic t_busy();
        int c;
        logic [7:0] d;
        wr(4'h0, 8'h01);
        count_starts(3, c);
        chk("R2 first start", c, 1);
        wr(4'h0, 8'h01);
        rd(4'h0, d);
        chk("R5 start bit stays 0 while busy", d[0], 0);
        count_starts(3, c);
        chk("R5 start ignored while busy", c, 0);
        pulse_line(8'h02);
        wr(4'h0, 8'h01);
        count_starts(3, c);
        chk("R6 no-data cmd ends on rsp done", c, 1);
        pulse_line(8'h04);
        clear_stats();
    endtask

    task automatic t_single();
        int c;
        logic [7:0] d;
        wr(4'h0, 8'h21);
        count_starts(3, c);
        pulse_line(8'h02);
        wr(4'h0, 8'h21);
        count_starts(3, c);
        chk("R6 single read busy in data", c, 0);
        pulse_blk();
        rd(4'hE, d);
        chk("R7 block done bit", d, 8'h20);
        wr(4'h0, 8'h21);
        count_starts(3, c);
        chk("R6 single ends on block", c, 1);
        pulse_line(8'h02);
        pulse_line(8'h10);
        wr(4'h0, 8'h21);
        count_starts(3, c);
        chk("R6 data timeout ends", c, 1);
        pulse_line(8'h04);
        clear_stats();
    endtask

    task automatic t_multi();
        int c;
        logic [7:0] d;
        wr(4'hA, 8'h03);
        wr(4'h0, 8'h41);
        count_starts(3, c);
        pulse_line(8'h02);
        pulse_blk();
        pulse_blk();
        rd(4'hE, d);
        chk("R7 no mblk before count", d, 8'h20);
        wr(4'h0, 8'h41);
        count_starts(3, c);
        chk("R6 multi busy before count", c, 0);
        pulse_blk();
        rd(4'hE, d);
        chk("R7 mblk at count", d, 8'h30);
        wr(4'h0, 8'h41);
        count_starts(3, c);
        chk("R6 multi ends at count", c, 1);
        pulse_line(8'h04);
        clear_stats();
    endtask

    task automatic t_crc();
        int c;
        wr(4'h9, 8'h00);
        wr(4'h0, 8'h21);
        count_starts(3, c);
        pulse_line(8'h02);
        pulse_line(8'h40);
        wr(4'h0, 8'h21);
        count_starts(3, c);
        chk("R6 crc ignored without abort", c, 0);
        wr(4'h9, 8'h08);
        pulse_line(8'h80);
        wr(4'h0, 8'h21);
        count_starts(3, c);
        chk("R6 crc aborts with abort set", c, 1);
        pulse_line(8'h04);
        wr(4'h9, 8'h00);
        clear_stats();
    endtask

    task automatic t_cd();
        logic [7:0] d;
        wr(4'h9, 8'h20);
        cd_dat3_evt = 1'b1; step(); cd_dat3_evt = 1'b0;
        rd(4'hE, d);
        chk("R7 dat3 ignored with gpi select", d, 8'h00);
        cd_gpi_evt = 1'b1; step(); cd_gpi_evt = 1'b0;
        rd(4'hE, d);
        chk("R7 gpi card detect", d, 8'h40);
        clear_stats();
        wr(4'h9, 8'h00);
        cd_gpi_evt = 1'b1; step(); cd_gpi_evt = 1'b0;
        rd(4'hE, d);
        chk("R7 gpi ignored with dat3 select", d, 8'h00);
        cd_dat3_evt = 1'b1; step(); cd_dat3_evt = 1'b0;
        dev_ins_evt = 1'b1; step(); dev_ins_evt = 1'b0;
        rd(4'hE, d);
        chk("R7 dat3 detect and insertion", d, 8'hC0);
        clear_stats();
    endtask

    task automatic t_wp_w1c();
        logic [7:0] d;
        wp_level = 1'b1;
        #1;
        rd(4'hE, d);
        chk("R7 write protect live", d, 8'h02);
        wr(4'hE, 8'hFF);
        rd(4'hE, d);
        chk("R9 write protect not cleared", d, 8'h02);
        wp_level = 1'b0;
        pulse_line(8'hA5);
        rd(4'hF, d);
        chk("R8 status1 events", d, 8'hA5);
        wr(4'hF, 8'h05);
        rd(4'hF, d);
        chk("R9 partial clear", d, 8'hA0);
        reg_wr = 1'b1; reg_addr = 4'hF; reg_wdata = 8'hFF; line_evt = 8'h01;
        step();
        reg_wr = 1'b0; line_evt = '0;
        rd(4'hF, d);
        chk("R9 event beats clear", d, 8'h01);
    endtask

    task automatic t_irq();
        logic [7:0] d;
        wr(4'hD, 8'h01);
        chk("R10 irq needs enable", irq, 0);
        wr(4'h9, 8'h80);
        chk("R10 irq masked status", irq, 1);
        wr(4'hD, 8'h00);
        chk("R10 irq mask off", irq, 0);
        wr(4'hC, 8'hFF);
        rd(4'hC, d);
        chk("R10 mask0 low bits", d, 8'hF0);
        chk("R10 no status0 yet", irq, 0);
        pulse_blk();
        chk("R10 irq from status0", irq, 1);
        clear_stats();
        chk("R10 irq after clear", irq, 0);
    endtask

    task automatic t_soft();
        int c;
        logic [7:0] d;
        pulse_line(8'h0C);
        wr(4'hD, 8'h0C);
        wr(4'h0, 8'h01);
        count_starts(2, c);
        wr(4'h3, 8'h83);
        chk("R11 bus cfg bit7 clear", bus_cfg, 8'h03);
        rd(4'hF, d);
        chk("R11 status cleared", d, 8'h00);
        rd(4'hD, d);
        chk("R11 mask kept", d, 8'h0C);
        chk("R11 index kept", cmd_index, 6'h2A);
        wr(4'h0, 8'h01);
        count_starts(3, c);
        chk("R11 sequencer idle after reset", c, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step();
        t_reset();
        t_fields();
        t_start();
        t_fifo();
        t_busy();
        t_single();
        t_multi();
        t_crc();
        t_cd();
        t_wp_w1c();
        t_irq();
        t_soft();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule